// File: doc/BRIEF.md
# Operand Address Resolver

This unit takes the addressing mode and the operand bytes of an 8-bit processor instruction, together with the X and Y index registers, and works out what the instruction operates on. Each request ends in one of four result kinds: no operand, an immediate byte, a signed branch offset, or a 16-bit effective address. Opcode decoding, execution and branch-target arithmetic belong to the neighbouring logic.

A request is made by raising `start` for one cycle with `mode`, `opnd_lo`, `opnd_hi`, `idx_x` and `idx_y` valid. Modes that need no memory finish on the next cycle. The three pointer modes (indirect, pre-indexed by X, post-indexed by Y) must fetch a two-byte little-endian pointer over a byte-wide read port. That port returns data one cycle after `mem_re`. Two reads are made before the result is ready. A single `done` pulse marks the result, and `res_kind` and `res_value` are valid in that same cycle.

The controller has four states. `ST_IDLE` waits for `start`. A pointer-mode start moves it to `ST_RD_LO`, which reads the low pointer byte. `ST_RD_HI` follows and reads the high byte. `ST_JOIN` comes next, where the fetched bytes are combined and indexed, and it always returns to `ST_IDLE`. A start for a mode that needs no memory leaves the controller in `ST_IDLE`.

Top module: `eag_unit`

## Requirements
- R1: While reset is held, and after it is released until the first request, `done`, `mem_re`, `res_kind` and `res_value` are all zero.
- R2: Mode codes 0 and 1, and the unassigned codes 13 to 15, produce `res_kind` 0 (no operand) with `res_value` 0. `done` rises in the cycle after `start` is accepted.
- R3: Mode code 2 produces `res_kind` 1 (immediate) with `res_value` = {8'h00, opnd_lo}. This happens one cycle after start.
- R4: Mode code 6 produces `res_kind` 2 (relative) with `res_value` = opnd_lo sign-extended to 16 bits. This happens one cycle after start.
- R5: Mode codes 3, 4 and 5 produce `res_kind` 3 (address) with the upper byte of `res_value` zero. The lower byte is opnd_lo, (opnd_lo+X) mod 256, or (opnd_lo+Y) mod 256 respectively.
- R6: Mode codes 7, 8 and 9 produce `res_kind` 3 with `res_value` = {opnd_hi, opnd_lo}, plus nothing, zero-extended X, or zero-extended Y respectively. The sum is taken modulo 65536.
- R7: Mode code 10 reads address P = {opnd_hi, opnd_lo} and then P+1 (16-bit wrap). The result is `res_kind` 3 with `res_value` = {byte at P+1, byte at P}.
- R8: Mode code 11 uses pointer P = {8'h00, (opnd_lo+X) mod 256}. It reads P and then P+1 as a full 16-bit increment, so 0x00FF is followed by 0x0100. The result is `res_kind` 3 and {byte at P+1, byte at P}.
- R9: Mode code 12 reads P = {8'h00, opnd_lo} and P+1. The result is `res_kind` 3 and ({byte at P+1, byte at P} + Y) mod 65536.
- R10: For a pointer mode, `mem_re` is high in the first and second cycles after acceptance, carrying P and then P+1. `done` is high in the fourth cycle only. Outside these reads `mem_re` is low, and `done` is high only in a result cycle.
- R11: A `start` that arrives while a pointer fetch is in progress is ignored. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| done | output | 1 | Result valid pulse |
| res_kind | output | 2 | 0 none, 1 immediate, 2 relative, 3 address |
| res_value | output | 16 | Result value |

## Verification
Two events can fall in the same cycle: the `done` pulse of one request and the acceptance of the next `start`. The bench provokes this by issuing a new request exactly on the result cycle of a pointer fetch, and by sending direct-mode requests on every clock. It also keeps `start` high with junk modes through the busy cycles of a fetch. The reference model predicts, for every clock, whether `done` and `mem_re` are high and what they carry. The held-start cycles must therefore produce no extra result and no disturbed read, while the request in the done cycle must finish on schedule.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MD_ACCUM      = 4'd0;
    localparam logic [MODE_W-1:0] MD_IMPL       = 4'd1;
    localparam logic [MODE_W-1:0] MD_IMM        = 4'd2;
    localparam logic [MODE_W-1:0] MD_PAGE0      = 4'd3;
    localparam logic [MODE_W-1:0] MD_PAGE0_X    = 4'd4;
    localparam logic [MODE_W-1:0] MD_PAGE0_Y    = 4'd5;
    localparam logic [MODE_W-1:0] MD_REL        = 4'd6;
    localparam logic [MODE_W-1:0] MD_FULL       = 4'd7;
    localparam logic [MODE_W-1:0] MD_FULL_X     = 4'd8;
    localparam logic [MODE_W-1:0] MD_FULL_Y     = 4'd9;
    localparam logic [MODE_W-1:0] MD_PTR        = 4'd10;
    localparam logic [MODE_W-1:0] MD_PRE_X_PTR  = 4'd11;
    localparam logic [MODE_W-1:0] MD_PTR_POST_Y = 4'd12;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_IMM  = 2'd1,
        RK_REL  = 2'd2,
        RK_ADDR = 2'd3
    } res_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2,
        ST_JOIN  = 2'd3
    } eag_state_t;

    function automatic logic mode_fetches(input logic [MODE_W-1:0] m);
        return (m == MD_PTR) || (m == MD_PRE_X_PTR) || (m == MD_PTR_POST_Y);
    endfunction

endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
    parameter int AW = 16,
    parameter int IW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] sum
);
    localparam int PAD = AW - IW;

    assign sum = base + {{PAD{1'b0}}, idx};
endmodule

// File: rtl/eag_direct.sv
module eag_direct
    import eag_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output res_kind_t         kind,
    output logic [AW-1:0]     value,
    output logic              fetch
);
    logic [DW-1:0] page0_x;
    logic [DW-1:0] page0_y;
    logic [DW-1:0] full_idx;
    logic [AW-1:0] full_base;
    logic [AW-1:0] full_sum;

    assign page0_x   = opnd_lo + idx_x;
    assign page0_y   = opnd_lo + idx_y;
    assign full_base = {opnd_hi, opnd_lo};
    assign full_idx  = (mode == MD_FULL_Y) ? idx_y : idx_x;

    eag_index_add #(.AW(AW), .IW(DW)) u_full_add (
        .base (full_base),
        .idx  (full_idx),
        .sum  (full_sum)
    );

    always_comb begin
        kind  = RK_NONE;
        value = '0;
        fetch = 1'b0;
        unique case (mode)
            MD_IMM: begin
                kind  = RK_IMM;
                value = {{DW{1'b0}}, opnd_lo};
            end
            MD_REL: begin
                kind  = RK_REL;
                value = {{DW{opnd_lo[DW-1]}}, opnd_lo};
            end
            MD_PAGE0: begin
                kind  = RK_ADDR;
                value = {{DW{1'b0}}, opnd_lo};
            end
            MD_PAGE0_X: begin
                kind  = RK_ADDR;
                value = {{DW{1'b0}}, page0_x};
            end
            MD_PAGE0_Y: begin
                kind  = RK_ADDR;
                value = {{DW{1'b0}}, page0_y};
            end
            MD_FULL: begin
                kind  = RK_ADDR;
                value = full_base;
            end
            MD_FULL_X, MD_FULL_Y: begin
                kind  = RK_ADDR;
                value = full_sum;
            end
            MD_PTR, MD_PRE_X_PTR, MD_PTR_POST_Y: begin
                fetch = 1'b1;
            end
            default: begin
                kind  = RK_NONE;
                value = '0;
            end
        endcase
    end
endmodule

// File: rtl/eag_ptr_base.sv
module eag_ptr_base
    import eag_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    output logic [AW-1:0]     ptr,
    output logic              post_y
);
    logic [DW-1:0] pre_x;

    assign pre_x = opnd_lo + idx_x;

    always_comb begin
        ptr    = '0;
        post_y = 1'b0;
        unique case (mode)
            MD_PTR:        ptr = {opnd_hi, opnd_lo};
            MD_PRE_X_PTR:  ptr = {{DW{1'b0}}, pre_x};
            MD_PTR_POST_Y: begin
                ptr    = {{DW{1'b0}}, opnd_lo};
                post_y = 1'b1;
            end
            default:       ptr = '0;
        endcase
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic              mem_re,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic [1:0]        res_kind,
    output logic [AW-1:0]     res_value
);
    eag_state_t    state_q, state_d;
    res_kind_t     dir_kind;
    logic [AW-1:0] dir_value;
    logic          dir_fetch;
    logic [AW-1:0] base_ptr;
    logic          base_post_y;

    logic [AW-1:0] ptr_q;
    logic [DW-1:0] y_q;
    logic          post_y_q;
    logic [DW-1:0] lo_q;

    logic          accept;
    logic          busy;
    logic          rd_first;
    logic [AW-1:0] joined;
    logic [AW-1:0] joined_y;
    logic [AW-1:0] fetched;

    res_kind_t     kind_q;
    logic [AW-1:0] value_q;
    logic          done_q;

    eag_direct #(.DW(DW)) u_direct (
        .mode    (mode),
        .opnd_lo (opnd_lo),
        .opnd_hi (opnd_hi),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .kind    (dir_kind),
        .value   (dir_value),
        .fetch   (dir_fetch)
    );

    eag_ptr_base #(.DW(DW)) u_ptr_base (
        .mode    (mode),
        .opnd_lo (opnd_lo),
        .opnd_hi (opnd_hi),
        .idx_x   (idx_x),
        .ptr     (base_ptr),
        .post_y  (base_post_y)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign busy     = (state_q != ST_IDLE);
    assign rd_first = (state_q == ST_RD_LO);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && dir_fetch) state_d = ST_RD_LO;
            ST_RD_LO: state_d = ST_RD_HI;
            ST_RD_HI: state_d = ST_JOIN;
            ST_JOIN:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pointer context captured at acceptance and during the low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            y_q      <= '0;
            post_y_q <= 1'b0;
            lo_q     <= '0;
        end else begin
            if (accept && dir_fetch) begin
                ptr_q    <= base_ptr;
                y_q      <= idx_y;
                post_y_q <= base_post_y;
            end
            if (state_q == ST_RD_HI) lo_q <= mem_rdata;
        end
    end

    // Memory port (Moore)
    assign mem_re   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    assign mem_addr = (state_q == ST_RD_HI) ? AW'(ptr_q + 1'b1) : ptr_q;

    // Combine fetched pointer bytes
    assign joined = {mem_rdata, lo_q};

    eag_index_add #(.AW(AW), .IW(DW)) u_post_add (
        .base (joined),
        .idx  (y_q),
        .sum  (joined_y)
    );

    assign fetched = post_y_q ? joined_y : joined;

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            kind_q  <= RK_NONE;
            value_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept && !dir_fetch) begin
                done_q  <= 1'b1;
                kind_q  <= dir_kind;
                value_q <= dir_value;
            end else if (state_q == ST_JOIN) begin
                done_q  <= 1'b1;
                kind_q  <= RK_ADDR;
                value_q <= fetched;
            end
        end
    end

    assign done      = done_q;
    assign res_kind  = kind_q;
    assign res_value = value_q;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk
    import eag_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [MODE_W-1:0] mode,
    input logic              mem_re,
    input logic [AW-1:0]     mem_addr,
    input logic              done,
    input logic [1:0]        res_kind,
    input logic [AW-1:0]     res_value,
    input logic              busy,
    input logic              rd_first
);
    p_none_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (mode == MD_ACCUM || mode == MD_IMPL || mode > MD_PTR_POST_Y))
        |=> (done && res_kind == 2'd0 && res_value == '0));

    p_direct_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !mode_fetches(mode)) |=> done);

    p_page0_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (mode == MD_PAGE0 || mode == MD_PAGE0_X || mode == MD_PAGE0_Y))
        |=> (res_kind == 2'd3 && res_value[AW-1:DW] == '0));

    p_read_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_first |=> (mem_re && mem_addr == AW'($past(mem_addr) + 1'b1)));

    p_fetch_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_first |-> ##3 done);

    p_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind eag_unit eag_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .done      (done),
    .res_kind  (res_kind),
    .res_value (res_value),
    .busy      (busy),
    .rd_first  (rd_first)
);

// File: tb/eag_unit_tb.sv
`timescale 1ns/1ps
module eag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [1:0]  res_kind;
    logic [15:0] res_value;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct { int cyc; logic [1:0] kind; logic [15:0] val; string tag; } res_exp_t;
    typedef struct { int cyc; logic [15:0] addr; string tag; } rd_exp_t;
    res_exp_t dq[$];
    rd_exp_t  rq[$];

    always #2.5 clk = ~clk;

    eag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .res_kind(res_kind), .res_value(res_value)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= mem_byte(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, expv);
        end
    endtask

    // Per-clock comparison against the reference model
    always @(negedge clk) begin
        if (!finished) begin
            if (dq.size() > 0 && dq[0].cyc == cyc) begin
                chk(done === 1'b1 && res_kind === dq[0].kind && res_value === dq[0].val, dq[0].tag,
                    {13'd0, done, res_kind, res_value}, {13'd0, 1'b1, dq[0].kind, dq[0].val});
                void'(dq.pop_front());
            end else begin
                chk(done === 1'b0, "R10 R11 stray done", {31'd0, done}, 32'd0);
            end
            if (rq.size() > 0 && rq[0].cyc == cyc) begin
                chk(mem_re === 1'b1 && mem_addr === rq[0].addr, rq[0].tag,
                    {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, rq[0].addr});
                void'(rq.pop_front());
            end else begin
                chk(mem_re === 1'b0, "R10 stray read", {31'd0, mem_re}, 32'd0);
            end
        end
    end

    function automatic bit is_fetch(input logic [3:0] m);
        return m == 4'd10 || m == 4'd11 || m == 4'd12;
    endfunction

    task automatic send(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y);
        res_exp_t e;
        rd_exp_t  r;
        int p;
        int v;
        @(negedge clk); #1;
        start = 1'b1; mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y;
        e.kind = 2'd3; e.cyc = cyc + 1; v = 0;
        case (m)
            4'd2:  begin e.kind = 2'd1; v = lo;                 e.tag = "R3 immediate"; end
            4'd6:  begin e.kind = 2'd2; v = (lo >= 128) ? lo + 16'hFF00 : lo; e.tag = "R4 relative"; end
            4'd3:  begin v = lo;                                e.tag = "R5 page zero"; end
            4'd4:  begin v = (lo + x) % 256;                    e.tag = "R5 page zero X"; end
            4'd5:  begin v = (lo + y) % 256;                    e.tag = "R5 page zero Y"; end
            4'd7:  begin v = hi * 256 + lo;                     e.tag = "R6 full"; end
            4'd8:  begin v = (hi * 256 + lo + x) % 65536;       e.tag = "R6 full X"; end
            4'd9:  begin v = (hi * 256 + lo + y) % 65536;       e.tag = "R6 full Y"; end
            4'd10: begin p = hi * 256 + lo;                     e.tag = "R7 pointer"; end
            4'd11: begin p = (lo + x) % 256;                    e.tag = "R8 pre-X pointer"; end
            4'd12: begin p = lo;                                e.tag = "R9 post-Y pointer"; end
            default: begin e.kind = 2'd0; v = 0;                e.tag = "R2 no operand"; end
        endcase
        if (is_fetch(m)) begin
            v = mem_byte(16'((p + 1) % 65536)) * 256 + mem_byte(16'(p));
            if (m == 4'd12) v = (v + y) % 65536;
            e.cyc = cyc + 4;
            r.cyc = cyc + 1; r.addr = 16'(p);               r.tag = {e.tag, " R10 first read"};
            rq.push_back(r);
            r.cyc = cyc + 2; r.addr = 16'((p + 1) % 65536); r.tag = {e.tag, " R10 second read"};
            rq.push_back(r);
        end
        e.val = 16'(v);
        dq.push_back(e);
    endtask

    task automatic quiet(input int k);
        repeat (k) begin
            @(negedge clk); #1;
            start = 1'b0;
        end
    endtask

    // Start held or toggled during a fetch: must be ignored (R11)
    task automatic busy_noise(input bit rnd);
        repeat (3) begin
            @(negedge clk); #1;
            start = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
            mode = rnd ? 4'($urandom_range(0, 15)) : 4'd2;
            opnd_lo = 8'($urandom); opnd_hi = 8'($urandom);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired (R10) actual=running expected=finished");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && mem_re === 1'b0 && res_kind === 2'd0 && res_value === 16'd0,
            "R1 reset state", {13'd0, done, res_kind, res_value}, 32'd0);
        @(negedge clk); #1 rst_n = 1'b1;
        quiet(2);

        send(4'd0, 8'h55, 8'h66, 8'h01, 8'h02); quiet(1);           // R2
        send(4'd1, 8'hAA, 8'h00, 8'h00, 8'h00); quiet(1);           // R2
        send(4'd14, 8'h12, 8'h34, 8'h00, 8'h00); quiet(1);          // R2 unassigned
        send(4'd2, 8'h9C, 8'h11, 8'h00, 8'h00); quiet(1);           // R3
        send(4'd6, 8'h80, 8'h00, 8'h00, 8'h00); quiet(1);           // R4 negative
        send(4'd6, 8'h7F, 8'h00, 8'h00, 8'h00); quiet(1);           // R4 positive
        send(4'd3, 8'h42, 8'hEE, 8'h00, 8'h00); quiet(1);           // R5
        send(4'd4, 8'hF0, 8'hEE, 8'h20, 8'h00); quiet(1);           // R5 wrap
        send(4'd5, 8'h05, 8'hEE, 8'h00, 8'hFF); quiet(1);           // R5 wrap
        send(4'd7, 8'h34, 8'h12, 8'h00, 8'h00); quiet(1);           // R6
        send(4'd8, 8'hF0, 8'h12, 8'h20, 8'h00); quiet(1);           // R6 page cross
        send(4'd9, 8'hF0, 8'hFF, 8'h00, 8'h30); quiet(1);           // R6 16-bit wrap
        send(4'd10, 8'h56, 8'h34, 8'h00, 8'h00); quiet(4);          // R7
        send(4'd10, 8'hFF, 8'hFF, 8'h00, 8'h00); quiet(4);          // R7 wrap to 0000
        send(4'd11, 8'hFE, 8'h77, 8'h01, 8'h00); quiet(4);          // R8 00FF then 0100
        send(4'd11, 8'h10, 8'h77, 8'h25, 8'h00); quiet(4);          // R8
        send(4'd12, 8'h80, 8'h77, 8'h00, 8'hFF); quiet(4);          // R9
        send(4'd12, 8'hFF, 8'h00, 8'h00, 8'h01); quiet(4);          // R9 pointer at 00FF

        // R11: start held through a fetch, next request in the done cycle
        send(4'd11, 8'h40, 8'h00, 8'h03, 8'h00);
        busy_noise(1'b0);
        send(4'd2, 8'h5A, 8'h00, 8'h00, 8'h00);
        send(4'd12, 8'h20, 8'h00, 8'h00, 8'h10);
        busy_noise(1'b0);
        send(4'd10, 8'h00, 8'h90, 8'h00, 8'h00);
        busy_noise(1'b0);
        quiet(2);

        // Direct requests on every clock
        send(4'd4, 8'h01, 8'h00, 8'h02, 8'h00);
        send(4'd9, 8'h00, 8'h10, 8'h00, 8'h08);
        send(4'd6, 8'hFE, 8'h00, 8'h00, 8'h00);
        quiet(2);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            send(m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            if (is_fetch(m)) busy_noise(1'b1);
            if ($urandom_range(0, 3) == 0) quiet(1);
        end
        quiet(6);

        chk(dq.size() == 0 && rq.size() == 0, "R10 all results seen",
            32'(dq.size() + rq.size()), 32'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule